// File: doc/BRIEF.md
# SPI Packet Sequencer

This block paces a serial memory transfer that is cut into equal packets. Software programs a packet size and a packet count, both minus one. An activate command starts the transfer from idle. The sequencer then asks a downstream byte shifter for one byte at a time, using a request/ready handshake. It counts the bytes inside the current packet and counts the packets until the transfer is done. The shifter's bit-level clocking and the DMA addressing are outside this block.

Three modes control what happens between packets:
- **Pause.** The sequencer halts, raises a pause flag and waits for a resume command.
- **Continuous.** Bytes keep flowing across the packet boundary and chip select stays active.
- **Default.** Chip select drops for a fixed number of idle cycles.

A transfer with no data completes at once. Completion and pause are kept as sticky flags. A status read clears them, and two enables gate them onto one interrupt line. A software reset returns everything to idle.

Top module: `spi_pkt_seq`

## Requirements
- R1: `pkt_len_i` holds bytes-per-packet minus one. Each packet takes exactly `pkt_len_i`+1 byte handshakes, where a handshake is `byte_req_o` and `byte_rdy_i` both high at a rising edge. `byte_idx_o` counts 0 up to `pkt_len_i` within the packet.
- R2: `pkt_loop_i` holds packets minus one. A transfer consists of `pkt_loop_i`+1 packets, and `pkt_idx_o` shows the current packet number.
- R3: `act_i` in idle with `no_data_i` high makes no byte request. It sets completion flag `status_o[0]` at the sampling edge, and the sequencer stays idle.
- R4: `act_i` is ignored unless the sequencer is idle. `resume_i` is ignored unless the sequencer is paused.
- R5: With `pause_en_i` high, the end of every packet except the last moves the sequencer to paused. While paused, `paused_o` is 1, `cs_o` and `byte_req_o` are 0, and `status_o` reads 2 (bit 1 set). `resume_i` starts the next packet.
- R6: With `pause_en_i` low and `nonidle_i` high, `byte_req_o` and `cs_o` stay high across packet boundaries until the last byte.
- R7: With both `pause_en_i` and `nonidle_i` low, `cs_o` and `byte_req_o` go low for exactly GAP_CYC cycles between packets.
- R8: `sw_rst_i` has priority over every other input. At the next edge it returns the sequencer to idle, with both counters and both flags cleared.
- R9: The completion flag sets at the edge that takes the last handshake, and the sequencer is idle from that edge on. `irq_o` is (`status_o[0]` and `finish_ie_i`) or (`status_o[1]` and `pause_ie_i`).
- R10: `status_rd_i` clears both flags at the next edge. A flag set in the same cycle wins over the clear.
- R11: After reset the sequencer is idle, all outputs are 0 and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| act_i | input | 1 | start command (pulse) |
| resume_i | input | 1 | continue from pause (pulse) |
| sw_rst_i | input | 1 | software reset (pulse) |
| pkt_len_i | input | LEN_W | bytes per packet minus one |
| pkt_loop_i | input | LOOP_W | packets per transfer minus one |
| no_data_i | input | 1 | transfer has no data bytes |
| pause_en_i | input | 1 | pause after each packet |
| nonidle_i | input | 1 | gapless continuous mode |
| finish_ie_i | input | 1 | completion interrupt enable |
| pause_ie_i | input | 1 | pause interrupt enable |
| status_rd_i | input | 1 | status read, clears flags |
| byte_rdy_i | input | 1 | shifter accepts a byte |
| byte_req_o | output | 1 | byte request to shifter |
| cs_o | output | 1 | chip select active |
| busy_o | output | 1 | sequencer not idle |
| paused_o | output | 1 | sequencer paused |
| byte_idx_o | output | LEN_W | byte index in packet |
| pkt_idx_o | output | LOOP_W | packet index |
| status_o | output | 2 | bit0 completion, bit1 pause |
| irq_o | output | 1 | gated interrupt |

## Verification
Commands, handshakes and status reads take effect at the rising edge that samples them. State-derived outputs (`byte_req_o`, `cs_o`, `busy_o`, `paused_o`, both indices and the flags) therefore change at that same edge. `irq_o` additionally follows its enables with no register in between. The bench drives inputs one nanosecond after each rising edge. A behavioural model advances at every rising edge from the same inputs, and all outputs are compared at the falling edge, once both have settled. Directed checks after each scenario count observed handshakes against (length+1)×(loop+1) and probe the ignored commands through `busy_o` and `paused_o`.

// File: rtl/spi_pkt_seq_pkg.sv
package spi_pkt_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_PAUSE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o,
  output logic         at_lim_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_lim_o = (cnt_q == lim_i);

  // increments only happen below the limit, so the count never wraps
  p_no_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_q != '0));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import spi_pkt_seq_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       resume_i,
  input  logic       sw_rst_i,
  input  logic       no_data_i,
  input  logic       pause_en_i,
  input  logic       nonidle_i,
  input  logic       byte_rdy_i,
  input  logic       last_byte_i,
  input  logic       last_pkt_i,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       nodata_done_o,
  output logic       byte_fire_o,
  output logic       pkt_end_o,
  output logic       xfer_done_o,
  output logic       pause_set_o
);
  localparam int GW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC - 1);

  seq_state_e state_q, state_d;
  logic [GW-1:0] gap_q, gap_d;
  logic idle;

  assign idle          = (state_q == ST_IDLE);
  assign start_o       = idle && act_i && !no_data_i && !sw_rst_i;
  assign nodata_done_o = idle && act_i && no_data_i && !sw_rst_i;
  assign byte_fire_o   = (state_q == ST_SHIFT) && byte_rdy_i && !sw_rst_i;
  assign pkt_end_o     = byte_fire_o && last_byte_i;
  assign xfer_done_o   = pkt_end_o && last_pkt_i;
  assign pause_set_o   = pkt_end_o && !last_pkt_i && pause_en_i;

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = ST_SHIFT;
      ST_SHIFT: begin
        if (xfer_done_o)      state_d = ST_IDLE;
        else if (pause_set_o) state_d = ST_PAUSE;
        else if (pkt_end_o && !nonidle_i) begin
          state_d = ST_GAP;
          gap_d   = GAP_LOAD;
        end
      end
      ST_GAP: begin
        if (gap_q == '0) state_d = ST_SHIFT;
        else             gap_d   = gap_q - 1'b1;
      end
      ST_PAUSE: if (resume_i) state_d = ST_SHIFT;
      default:  state_d = ST_IDLE;
    endcase
    if (sw_rst_i) begin
      state_d = ST_IDLE;
      gap_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end

  assign state_o = state_q;

  p_gap_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && gap_q == '0 && !sw_rst_i) |=> (state_q == ST_SHIFT));
  p_sw_rst_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (state_q == ST_IDLE));
  p_pause_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE && !resume_i && !sw_rst_i) |=> (state_q == ST_PAUSE));
  p_act_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE && act_i && !resume_i && !sw_rst_i) |=> $stable(state_q));
endmodule

// File: rtl/seq_flags.sv
module seq_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_set_i,
  input  logic       pause_set_i,
  input  logic       rd_i,
  input  logic       sw_rst_i,
  input  logic       finish_ie_i,
  input  logic       pause_ie_i,
  output logic [1:0] status_o,
  output logic       irq_o
);
  logic done_q, pause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      pause_q <= 1'b0;
    end else if (sw_rst_i) begin
      done_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      // a set in the same cycle as a read wins
      if (done_set_i)  done_q <= 1'b1;
      else if (rd_i)   done_q <= 1'b0;
      if (pause_set_i) pause_q <= 1'b1;
      else if (rd_i)   pause_q <= 1'b0;
    end
  end

  assign status_o = {pause_q, done_q};
  assign irq_o    = (done_q && finish_ie_i) || (pause_q && pause_ie_i);

  p_rd_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_set_i && !pause_set_i) |=> (status_o == 2'b00));
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i && !sw_rst_i) |=> status_o[0]);
  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != 2'b00));
endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
  import spi_pkt_seq_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int LOOP_W  = 8,
  parameter int GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              resume_i,
  input  logic              sw_rst_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [LOOP_W-1:0] pkt_loop_i,
  input  logic              no_data_i,
  input  logic              pause_en_i,
  input  logic              nonidle_i,
  input  logic              finish_ie_i,
  input  logic              pause_ie_i,
  input  logic              status_rd_i,
  input  logic              byte_rdy_i,
  output logic              byte_req_o,
  output logic              cs_o,
  output logic              busy_o,
  output logic              paused_o,
  output logic [LEN_W-1:0]  byte_idx_o,
  output logic [LOOP_W-1:0] pkt_idx_o,
  output logic [1:0]        status_o,
  output logic              irq_o
);
  seq_state_e state;
  logic start, nodata_done, byte_fire, pkt_end, xfer_done, pause_set;
  logic last_byte, last_pkt;

  seq_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
    .clk_i, .rst_ni, .act_i, .resume_i, .sw_rst_i, .no_data_i,
    .pause_en_i, .nonidle_i, .byte_rdy_i,
    .last_byte_i   (last_byte),
    .last_pkt_i    (last_pkt),
    .state_o       (state),
    .start_o       (start),
    .nodata_done_o (nodata_done),
    .byte_fire_o   (byte_fire),
    .pkt_end_o     (pkt_end),
    .xfer_done_o   (xfer_done),
    .pause_set_o   (pause_set)
  );

  seq_counter #(.W(LEN_W)) u_byte_cnt (
    .clk_i, .rst_ni,
    .clr_i    (sw_rst_i || start || pkt_end),
    .inc_i    (byte_fire && !last_byte),
    .lim_i    (pkt_len_i),
    .cnt_o    (byte_idx_o),
    .at_lim_o (last_byte)
  );

  seq_counter #(.W(LOOP_W)) u_pkt_cnt (
    .clk_i, .rst_ni,
    .clr_i    (sw_rst_i || start || xfer_done),
    .inc_i    (pkt_end && !last_pkt),
    .lim_i    (pkt_loop_i),
    .cnt_o    (pkt_idx_o),
    .at_lim_o (last_pkt)
  );

  seq_flags u_flags (
    .clk_i, .rst_ni,
    .done_set_i  (xfer_done || nodata_done),
    .pause_set_i (pause_set),
    .rd_i        (status_rd_i),
    .sw_rst_i,
    .finish_ie_i,
    .pause_ie_i,
    .status_o,
    .irq_o
  );

  assign byte_req_o = (state == ST_SHIFT);
  assign cs_o       = (state == ST_SHIFT);
  assign busy_o     = (state != ST_IDLE);
  assign paused_o   = (state == ST_PAUSE);

  p_cs_nonidle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end && !last_pkt && nonidle_i && !pause_en_i) |=> cs_o);
  p_nodata_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nodata_done |=> !busy_o);
endmodule

// File: tb/tb_spi_pkt_seq.sv
`timescale 1ns/1ps
module tb_spi_pkt_seq;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic act = 0, resume = 0, sw_rst = 0, no_data = 0, pause_en = 0, nonidle = 0;
  logic fie = 0, pie = 0, rd = 0, rdy = 0, rdy_toggle = 0;
  logic [15:0] len = 0;
  logic [7:0]  loop_n = 0;
  logic byte_req, cs, busy, paused, irq;
  logic [15:0] byte_idx;
  logic [7:0]  pkt_idx;
  logic [1:0]  status;

  int checks = 0, errors = 0, cyc = 0, d_fire = 0;
  int m_st = 0, m_b = 0, m_p = 0, m_g = 0;
  bit m_done = 0, m_pause = 0;

  always #4 clk = ~clk;

  spi_pkt_seq #(.GAP_CYC(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .resume_i(resume), .sw_rst_i(sw_rst),
    .pkt_len_i(len), .pkt_loop_i(loop_n), .no_data_i(no_data), .pause_en_i(pause_en),
    .nonidle_i(nonidle), .finish_ie_i(fie), .pause_ie_i(pie), .status_rd_i(rd),
    .byte_rdy_i(rdy), .byte_req_o(byte_req), .cs_o(cs), .busy_o(busy), .paused_o(paused),
    .byte_idx_o(byte_idx), .pkt_idx_o(pkt_idx), .status_o(status), .irq_o(irq)
  );

  task automatic cmp(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  // reference model: 0 idle, 1 shift, 2 gap, 3 pause
  always @(posedge clk) begin
    bit dset, pset;
    dset = 0; pset = 0;
    if (!rst_n) begin
      m_st = 0; m_b = 0; m_p = 0; m_g = 0; m_done = 0; m_pause = 0;
    end else if (sw_rst) begin
      m_st = 0; m_b = 0; m_p = 0; m_g = 0; m_done = 0; m_pause = 0;
    end else begin
      case (m_st)
        0: if (act) begin
             if (no_data) dset = 1;
             else begin m_st = 1; m_b = 0; m_p = 0; end
           end
        1: if (rdy) begin
             if (m_b == int'(len)) begin
               m_b = 0;
               if (m_p == int'(loop_n)) begin m_st = 0; m_p = 0; dset = 1; end
               else begin
                 m_p++;
                 if (pause_en) begin m_st = 3; pset = 1; end
                 else if (!nonidle) begin m_st = 2; m_g = GAP - 1; end
               end
             end else m_b++;
           end
        2: if (m_g == 0) m_st = 1; else m_g--;
        3: if (resume) m_st = 1;
        default: m_st = 0;
      endcase
      if (dset) m_done = 1; else if (rd) m_done = 0;
      if (pset) m_pause = 1; else if (rd) m_pause = 0;
    end
  end

  always @(posedge clk) if (rst_n && byte_req && rdy) d_fire++;

  always @(posedge clk) begin
    #1;
    if (rdy_toggle) rdy = ~rdy; else rdy = 1'b1;
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) if (rst_n) begin
    cmp("R1 byte_idx", byte_idx, m_b);
    cmp("R2 pkt_idx", pkt_idx, m_p);
    cmp("R6 byte_req", byte_req, m_st == 1);
    cmp("R7 cs", cs, m_st == 1);
    cmp("R4 busy", busy, m_st != 0);
    cmp("R5 paused", paused, m_st == 3);
    cmp("R9 status", status, {m_pause, m_done});
    cmp("R9 irq", irq, (m_done && fie) || (m_pause && pie));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_act();    act = 1;    step(); act = 0;    endtask
  task automatic pulse_resume(); resume = 1; step(); resume = 0; endtask
  task automatic pulse_rd();     rd = 1;     step(); rd = 0;     endtask
  task automatic pulse_rst();    sw_rst = 1; step(); sw_rst = 0; endtask

  task automatic wait_idle();
    while (busy) step();
  endtask

  task automatic wait_paused();
    while (!paused) step();
  endtask

  initial begin
    step(2);
    // R11 reset state
    cmp("R11 busy", busy, 0);
    cmp("R11 byte_req", byte_req, 0);
    cmp("R11 status", status, 0);
    cmp("R11 irq", irq, 0);
    rst_n = 1;
    step(2);

    // default gap mode, 4 bytes x 3 packets
    len = 3; loop_n = 2; fie = 1; d_fire = 0;
    pulse_act();
    wait_idle();
    cmp("R1 R2 handshakes", d_fire, 12);
    cmp("R9 done flag", status, 1);
    cmp("R9 irq", irq, 1);
    pulse_rd();
    cmp("R10 cleared", status, 0);

    // continuous mode, shifter ready every other cycle, read held high
    len = 1; loop_n = 3; nonidle = 1; rdy_toggle = 1; d_fire = 0; rd = 1;
    pulse_act();
    wait_idle();
    step();
    rd = 0;
    cmp("R6 handshakes", d_fire, 8);
    cmp("R10 read held", status, 0);
    rdy_toggle = 0; nonidle = 0;

    // pause mode, 3 bytes x 3 packets
    len = 2; loop_n = 2; pause_en = 1; pie = 1; d_fire = 0;
    pulse_act();
    wait_paused();
    cmp("R5 pause code", status, 2);
    cmp("R5 irq", irq, 1);
    cmp("R5 bytes so far", d_fire, 3);
    pulse_act();
    cmp("R4 act ignored", paused, 1);
    pulse_rd();
    cmp("R10 pause cleared", status, 0);
    step(3);
    cmp("R5 stays paused", paused, 1);
    pulse_resume();
    wait_paused();
    pulse_resume();
    wait_idle();
    cmp("R2 pause handshakes", d_fire, 9);
    cmp("R9 done after pauses", status[0], 1);
    pulse_rd();
    pause_en = 0; pie = 0;

    // zero-length transfer
    no_data = 1; d_fire = 0;
    pulse_act();
    cmp("R3 done", status, 1);
    cmp("R3 idle", busy, 0);
    step(2);
    cmp("R3 no bytes", d_fire, 0);
    no_data = 0;
    pulse_rd();

    // resume while idle
    pulse_resume();
    cmp("R4 resume ignored", busy, 0);

    // software reset mid-transfer
    len = 7; loop_n = 3;
    pulse_act();
    step(5);
    pulse_rst();
    cmp("R8 idle", busy, 0);
    cmp("R8 byte_idx", byte_idx, 0);
    cmp("R8 pkt_idx", pkt_idx, 0);
    cmp("R8 status", status, 0);
    step(3);
    cmp("R8 stays idle", busy, 0);

    // single-byte single-packet transfer
    len = 0; loop_n = 0; d_fire = 0;
    pulse_act();
    wait_idle();
    cmp("R1 single byte", d_fire, 1);
    step(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule